// File: doc/BRIEF.md
# Vertical-Blank Interrupt Controller

This block raises a single level-sensitive interrupt request for a display pipeline whose only interrupt source is the vertical-blank event. It contains a free-running frame tick generator, a 32-bit interrupt enable register and a 32-bit interrupt status register. Software reaches both registers over a plain register bus with separate write and read strobes.

A frame tick fires once every `TICK_CYCLES` clock cycles. The default is the clock rate divided by sixty, which gives a 60 Hz frame rate. Each tick sets the vblank status bit. Writing the enable register with the vblank bit set does two things: it posts a vblank event at once and it restarts the frame period. Writing the enable register with that bit clear stops the tick generator completely. Software acknowledges an event by writing ones to the status register. Only the bits inside a fixed writable mask respond to such a write.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when some bit is set in both the status register and the enable register. It follows every register update from the next clock edge on.
- R2: A status-register write clears each bit that is set in both the written data and the mask 0x000F040F. Writing a 0 bit, or any bit outside the mask, leaves the status unchanged.
- R3: While the generator runs, a tick falls every `TICK_CYCLES` cycles, counted from the clock edge that restarted it. Each tick sets status bit 0.
- R4: An enable-register write with bit 0 set sets status bit 0 at that same clock edge and restarts the tick period.
- R5: An enable-register write with bit 0 clear stops the tick generator. No later tick sets the status until a new enable write with bit 0 set.
- R6: After reset, both registers are zero, `irq_o` is low and the tick generator is stopped.
- R7: The enable register keeps all 32 written bits. It reads at offset 0x0 and the status register reads at offset 0x4. Any other offset reads 0. Read data appears on `rdata_o` at the clock edge that samples `rd_en_i`.
- R8: When a tick and a status write that clears bit 0 fall on the same clock edge, the tick wins and bit 0 ends up set.
- R9: Only bit 0 of the status register can ever become set. All other status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a status acknowledge that lands on the exact clock edge of a tick. The bench gets there by counting cycles from a restart: it issues an enable write, acknowledges the immediate event, then waits `TICK_CYCLES-2` cycles so that the next clearing write lands on the tick edge. A shortened period lets long random runs, scored against a cycle model in the bench, also reach ticks that arrive right after a disable, a re-enable or an acknowledge.

// File: rtl/vbl_irq_pkg.sv
package vbl_irq_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ENA  = 2'd1,
      SEL_STS  = 2'd2
   } reg_sel_e;

   localparam logic [31:0] DEF_STS_WMASK = 32'h000F_040F;
endpackage

// File: rtl/vbl_tick_gen.sv
module vbl_tick_gen #(
   parameter int TICK_CYCLES = 2083333
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic stop_i,
   output logic tick_o,
   output logic running_o
);
   localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign tick_o    = run_q && (cnt_q == LAST);
   assign running_o = run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (restart_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (stop_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/vbl_reg_file.sv
module vbl_reg_file
   import vbl_irq_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 4,
   parameter int          ENA_OFS   = 0,
   parameter int          STS_OFS   = 4,
   parameter int          VBL_BIT   = 0,
   parameter logic [31:0] STS_WMASK = DEF_STS_WMASK,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              tick_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] en_o,
   output logic [DATA_W-1:0] sts_o,
   output logic              restart_o,
   output logic              stop_o
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(STS_WMASK);

   reg_sel_e          sel;
   logic [DATA_W-1:0] en_q, sts_q, sts_d, rd_mux;

   always_comb begin
      if (addr_i == ADDR_W'(ENA_OFS))      sel = SEL_ENA;
      else if (addr_i == ADDR_W'(STS_OFS)) sel = SEL_STS;
      else                                 sel = SEL_NONE;
   end

   assign restart_o = wr_en_i && (sel == SEL_ENA) && wdata_i[VBL_BIT];
   assign stop_o    = wr_en_i && (sel == SEL_ENA) && !wdata_i[VBL_BIT];

   always_comb begin
      sts_d = sts_q;
      if (wr_en_i && (sel == SEL_STS)) sts_d = sts_d & ~(wdata_i & WMASK);
      if (restart_o || tick_i)         sts_d[VBL_BIT] = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         sts_q <= '0;
      end else begin
         if (wr_en_i && (sel == SEL_ENA)) en_q <= wdata_i;
         sts_q <= sts_d;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_ENA: rd_mux = en_q;
         SEL_STS: rd_mux = sts_q;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      rdata_q <= '0;
            else if (rd_en_i) rdata_q <= rd_mux;
         end
         assign rdata_o = rdata_q;
      end else begin : g_rd_comb
         assign rdata_o = rd_en_i ? rd_mux : '0;
      end
   endgenerate

   assign en_o  = en_q;
   assign sts_o = sts_q;
endmodule

// File: rtl/vbl_irq_ctrl.sv
module vbl_irq_ctrl
   import vbl_irq_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 4,
   parameter int          ENA_OFS     = 0,
   parameter int          STS_OFS     = 4,
   parameter int          VBL_BIT     = 0,
   parameter logic [31:0] STS_WMASK   = DEF_STS_WMASK,
   parameter int          TICK_CYCLES = 2083333,
   parameter bit          READ_REG    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("vbl_irq_ctrl: DATA_W must be 32");
      end
      if (TICK_CYCLES < 2) begin : g_bad_period
         $error("vbl_irq_ctrl: TICK_CYCLES must be at least 2");
      end
      if (VBL_BIT < 0 || VBL_BIT >= DATA_W) begin : g_bad_bit
         $error("vbl_irq_ctrl: VBL_BIT out of range");
      end
      if (ENA_OFS == STS_OFS || ENA_OFS >= (1 << ADDR_W) || STS_OFS >= (1 << ADDR_W)) begin : g_bad_map
         $error("vbl_irq_ctrl: register offsets invalid");
      end
   endgenerate

   logic [DATA_W-1:0] en_q, sts_q;
   logic              tick, running, restart, stop;

   vbl_reg_file #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS), .STS_OFS(STS_OFS),
      .VBL_BIT(VBL_BIT), .STS_WMASK(STS_WMASK), .READ_REG(READ_REG)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .tick_i(tick), .rdata_o(rdata_o),
      .en_o(en_q), .sts_o(sts_q), .restart_o(restart), .stop_o(stop)
   );

   vbl_tick_gen #(
      .TICK_CYCLES(TICK_CYCLES)
   ) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .stop_i(stop),
      .tick_o(tick), .running_o(running)
   );

   assign irq_o = |(sts_q & en_q);
endmodule

// File: rtl/vbl_irq_ctrl_chk.sv
module vbl_irq_ctrl_chk #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int ENA_OFS     = 0,
   parameter int STS_OFS     = 4,
   parameter int VBL_BIT     = 0,
   parameter int TICK_CYCLES = 2083333
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              irq_o,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] sts_q,
   input logic              tick,
   input logic              running
);
   localparam logic [DATA_W-1:0] VBL_ONLY = DATA_W'(1) << VBL_BIT;

   logic ena_wr, sts_wr, restart_seen;
   logic [31:0] gap_q;

   assign ena_wr       = wr_en_i && (addr_i == ADDR_W'(ENA_OFS));
   assign sts_wr       = wr_en_i && (addr_i == ADDR_W'(STS_OFS));
   assign restart_seen = ena_wr && wdata_i[VBL_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                gap_q <= '0;
      else if (restart_seen || tick) gap_q <= '0;
      else if (running)           gap_q <= gap_q + 1'b1;
   end

   // R1: a raised request needs the vblank enable
   a_r1_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> en_q[VBL_BIT]);

   // R2: acknowledging bit 0 with no tick leaves it clear
   a_r2_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr && wdata_i[VBL_BIT] && !tick) |=> !sts_q[VBL_BIT]);

   // R3: ticks are spaced by the full period
   a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick |-> (gap_q == 32'(TICK_CYCLES - 1)));

   // R4: enabling posts an event at once
   a_r4_enable_posts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_seen |=> (sts_q[VBL_BIT] && running));

   // R5: disabling stops the generator
   a_r5_disable_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ena_wr && !wdata_i[VBL_BIT]) |=> !running);

   a_r5_idle_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !running |-> !tick);

   // R8: tick wins over acknowledge on the same edge
   a_r8_tick_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && sts_wr) |=> sts_q[VBL_BIT]);

   // R9: only the vblank bit can be set
   a_r9_only_vbl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(sts_q & ~VBL_ONLY) == 0);
endmodule

bind vbl_irq_ctrl vbl_irq_ctrl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS), .STS_OFS(STS_OFS),
   .VBL_BIT(VBL_BIT), .TICK_CYCLES(TICK_CYCLES)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
   .wdata_i(wdata_i), .irq_o(irq_o), .en_q(en_q), .sts_q(sts_q),
   .tick(tick), .running(running)
);

// File: tb/tb_vbl_irq_ctrl.sv
module tb_vbl_irq_ctrl;
   localparam int P = 50;
   localparam logic [31:0] MASK = 32'h000F_040F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit chk_on = 1'b0, done = 1'b0;

   always #4 clk = ~clk;

   vbl_irq_ctrl #(.TICK_CYCLES(P)) dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   // reference model built from the requirements
   logic [31:0] m_en, m_sts, m_rdata;
   bit          m_run, m_rd_pend;
   int          m_cnt;

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      if (a == 4'h0)      return m_en;
      else if (a == 4'h4) return m_sts;
      else                return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_sts = '0; m_run = 0; m_cnt = 0; m_rdata = '0; m_rd_pend = 0;
      end else begin
         bit t;
         t = m_run && (m_cnt == P - 1);
         m_rd_pend = rd_en;
         if (rd_en) m_rdata = exp_read(addr);
         if (wr_en && addr == 4'h0) begin
            m_en = wdata;
            if (wdata[0]) begin m_run = 1; m_cnt = 0; m_sts[0] = 1'b1; end
            else begin m_run = 0; m_cnt = 0; end
         end else if (t) m_cnt = 0;
         else if (m_run) m_cnt++;
         if (wr_en && addr == 4'h4) m_sts = m_sts & ~(wdata & MASK);
         if (t) m_sts[0] = 1'b1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (chk_on) begin
      chk("R1 irq level vs model", {31'b0, irq}, {31'b0, |(m_sts & m_en)});
      if (m_rd_pend) chk("R7 read data vs model", rdata, m_rdata);
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_on = 1'b1;

      // R6 reset state
      chk("R6 irq after reset", {31'b0, irq}, 32'h0);
      rd(4'h0, v); chk("R6 enable after reset", v, 32'h0);
      rd(4'h4, v); chk("R6 status after reset", v, 32'h0);
      repeat (2 * P) @(negedge clk);
      rd(4'h4, v); chk("R6 generator stopped after reset", v, 32'h0);

      // R7 full-width enable storage and decode
      wr(4'h0, 32'hA5A5_5A5A);
      rd(4'h0, v); chk("R7 enable readback", v, 32'hA5A5_5A5A);
      rd(4'h8, v); chk("R7 unmapped offset reads zero", v, 32'h0);
      chk("R1 no irq with status clear", {31'b0, irq}, 32'h0);

      // R4 enable posts an event at once
      wr(4'h0, 32'h0000_0001);
      chk("R4 irq right after enable", {31'b0, irq}, 32'h1);
      rd(4'h4, v); chk("R4 status bit set", v, 32'h1);

      // R2 / R9 writes outside bit 0 do nothing
      wr(4'h4, 32'hFFFF_FFFE);
      rd(4'h4, v); chk("R2 zero bit does not clear", v, 32'h1);
      chk("R9 no other status bits", v & 32'hFFFF_FFFE, 32'h0);
      wr(4'h4, 32'h0000_0001);
      chk("R2 ack clears irq", {31'b0, irq}, 32'h0);

      // R3 exact period after a restart
      wr(4'h0, 32'h0000_0001);
      wr(4'h4, 32'h0000_0001);
      repeat (P - 2) @(negedge clk);
      chk("R3 no tick before period", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R3 tick at period", {31'b0, irq}, 32'h1);

      // R8 tick and ack on the same edge
      wr(4'h0, 32'h0000_0001);
      wr(4'h4, 32'h0000_0001);
      repeat (P - 2) @(negedge clk);
      wr(4'h4, 32'h0000_0001);
      chk("R8 tick wins over ack", {31'b0, irq}, 32'h1);

      // R5 disable stops the generator; status stays until acked
      wr(4'h0, 32'h0000_0002);
      rd(4'h4, v); chk("R5 status kept after disable", v, 32'h1);
      chk("R1 irq low with bit 0 disabled", {31'b0, irq}, 32'h0);
      wr(4'h4, 32'h0000_0001);
      wr(4'h0, 32'h0000_0003);
      wr(4'h4, 32'h0000_0001);
      wr(4'h0, 32'h0000_0000);
      repeat (3 * P) @(negedge clk);
      rd(4'h4, v); chk("R5 no tick after disable", v, 32'h0);

      // random stimulus scored by the model
      for (int i = 0; i < 6000; i++) begin
         int op;
         op = $urandom % 16;
         if (op == 0)       wr(4'h0, $urandom);
         else if (op < 4)   wr(4'h4, $urandom);
         else if (op < 8)   begin
            logic [3:0] a;
            a = 4'($urandom % 4) << 2;
            rd(a, v);
         end
         else @(negedge clk);
      end

      done = 1'b1;
      summary();
   end
endmodule